// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a clocked host and an 8K x 8 static RAM that has no clock. The host offers one word at a time through a valid/ready handshake. Each request carries an address, a write flag and write data. The controller turns each accepted request into a complete cycle on the memory pins. It counts clock cycles so that every setup, pulse and hold minimum is met. Reads return their byte with a one-cycle valid pulse.

The memory is selected when its active-low select is low and its active-high select is high at the same time. A write happens only while both selects are active and the write strobe is low. The controller asserts the selects first and fires the write strobe last. It releases the write strobe before the selects. The memory's output enable is held high for the whole of a write, and the controller's own bus drivers turn on only after a turnaround count. This means the memory and the controller never drive the data bus together. The data bus leaves the block as a drive value, a drive enable and a sampled input, and the pad ring combines them.

All timing limits are given in nanoseconds with the clock period, and each one becomes a cycle count rounded upward. At the defaults (4 ns clock, 85 ns grade) these counts apply:
- a full cycle lasts 22 clocks;
- read data is captured 22 edges after acceptance;
- the write strobe is low for 14 clocks;
- the write strobe starts 2 clocks after acceptance.

Top module: `sramc`

## Requirements
- R1: While reset is high and after it is released, the block shows an idle state: `req_ready`=1, `sram_cs_n`=1, `sram_cs`=0, `sram_we_n`=1, `sram_oe_n`=1, `sram_dq_oe`=0 and `rd_valid`=0.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the edge that ends the cycle. That edge comes LEN edges after acceptance, where LEN = max(ceil(T_CYC/T), ceil(T_ACC/T)) for reads and max(ceil(T_CYC/T), TURN+WP+1) for writes, and `req_ready` is 1 again after it. Inputs that change while `req_ready` is 0 have no effect on any output.
- R3: During a read, from the cycle after acceptance until the end edge, `sram_cs_n`=0, `sram_cs`=1, `sram_oe_n`=0 and `sram_we_n`=1. After the end edge the memory is deselected and `sram_oe_n` is 1.
- R4: A read samples `sram_dq_i` on the edge ceil(T_ACC/T) cycles after acceptance. `rd_valid` is 1 for exactly the following cycle, and `rd_data` holds the sampled byte.
- R5: During a write, `sram_oe_n` stays 1. `sram_we_n` falls, and `sram_dq_oe` rises, on the edge TURN cycles after acceptance, so the output enable was already high the cycle before. `sram_dq_oe` is never 1 while `sram_oe_n` is 0.
- R6: The write strobe stays low for WP = max(ceil(T_WP/T), ceil(T_DS/T)) cycles.
- R7: The controller drives `sram_dq_o` with the accepted write data from the edge where the strobe falls until one cycle after it rises. After that, `sram_dq_oe` returns to 0.
- R8: `sram_addr` holds the accepted address and the selects stay active for the whole cycle. `sram_we_n` is 0 only while both selects are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | DW | Read data |
| sram_addr | output | AW | Memory address |
| sram_cs_n | output | 1 | Active-low select |
| sram_cs | output | 1 | Active-high select |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_dq_o | output | DW | Data driven toward the memory |
| sram_dq_oe | output | 1 | Drive enable for the data bus |
| sram_dq_i | input | DW | Data sampled from the memory |

## Verification
Every result is due a known number of edges after the acceptance edge:
- `req_ready` drops one cycle after acceptance;
- the strobes settle in that same cycle;
- the write strobe and the bus drivers change after edges TURN, TURN+WP and TURN+WP+1;
- `rd_valid` with its data appears after edge ceil(T_ACC/T);
- everything returns to idle after edge LEN.

The bench steps a behavioural model on each rising edge, using an integer edge count since acceptance. It compares every output at the following falling edge, so each check samples a value one full half-period after the edge that produced it. The memory model in the bench returns a dummy byte until a read has lasted long enough, so capturing too early shows up as wrong data.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

   // integer division rounded toward +infinity
   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sramc_phase.sv
// Edge counter for one memory cycle: cleared on start, advanced while busy.
module sramc_phase #(
   parameter int CW = 5
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic          stop,
   output logic          busy,
   output logic [CW-1:0] next_ph
);

   logic [CW-1:0] ph_q;

   assign next_ph = ph_q + CW'(1);

   always_ff @(posedge clk) begin
      if (rst) begin
         busy <= 1'b0;
         ph_q <= '0;
      end else if (start) begin
         busy <= 1'b1;
         ph_q <= '0;
      end else if (busy) begin
         ph_q <= next_ph;
         if (stop) busy <= 1'b0;
      end
   end

endmodule

// File: rtl/sramc_rcap.sv
// Read-data capture register with a one-cycle valid pulse.
module sramc_rcap #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          cap,
   input  logic [DW-1:0] din,
   output logic          vld,
   output logic [DW-1:0] dout
);

   always_ff @(posedge clk) begin
      if (rst) begin
         vld  <= 1'b0;
         dout <= '0;
      end else begin
         vld <= cap;
         if (cap) dout <= din;
      end
   end

endmodule

// File: rtl/sramc.sv
module sramc
   import sramc_pkg::*;
#(
   parameter int AW       = 13,
   parameter int DW       = 8,
   parameter int CLK_NS   = 4,
   parameter int T_CYC_NS = 85,
   parameter int T_ACC_NS = 85,
   parameter int T_WP_NS  = 55,
   parameter int T_DS_NS  = 40,
   parameter int TURN_CYC = 2
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          rd_valid,
   output logic [DW-1:0] rd_data,
   output logic [AW-1:0] sram_addr,
   output logic          sram_cs_n,
   output logic          sram_cs,
   output logic          sram_we_n,
   output logic          sram_oe_n,
   output logic [DW-1:0] sram_dq_o,
   output logic          sram_dq_oe,
   input  logic [DW-1:0] sram_dq_i
);

   // cycle counts derived from the nanosecond limits, rounded up
   localparam int CYC_C   = ceil_div(T_CYC_NS, CLK_NS);
   localparam int ACC_C   = ceil_div(T_ACC_NS, CLK_NS);
   localparam int WP_C    = max2(ceil_div(T_WP_NS, CLK_NS), ceil_div(T_DS_NS, CLK_NS));
   localparam int WE_ON   = TURN_CYC;
   localparam int WE_OFF  = TURN_CYC + WP_C;
   localparam int DRV_OFF = WE_OFF + 1;
   localparam int RD_LEN  = max2(CYC_C, ACC_C);
   localparam int WR_LEN  = max2(CYC_C, DRV_OFF);
   localparam int LAST    = max2(RD_LEN, WR_LEN);
   localparam int CW      = $clog2(LAST + 1);

   if (CLK_NS < 1) begin : g_bad_clk
      $error("sramc: CLK_NS must be at least 1");
   end
   if (TURN_CYC < 1) begin : g_bad_turn
      $error("sramc: TURN_CYC must be at least 1 so OE is high before WE falls");
   end
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("sramc: AW and DW must be positive");
   end

   logic          busy;
   logic [CW-1:0] k;
   logic          wr_q;
   logic          accept;
   logic          done;
   logic          cap;

   assign accept = req_valid && req_ready;
   assign done   = busy && (k == (wr_q ? CW'(WR_LEN) : CW'(RD_LEN)));
   assign cap    = busy && !wr_q && (k == CW'(ACC_C));

   sramc_phase #(.CW(CW)) u_phase (
      .clk     (clk),
      .rst     (rst),
      .start   (accept),
      .stop    (done),
      .busy    (busy),
      .next_ph (k)
   );

   sramc_rcap #(.DW(DW)) u_rcap (
      .clk  (clk),
      .rst  (rst),
      .cap  (cap),
      .din  (sram_dq_i),
      .vld  (rd_valid),
      .dout (rd_data)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         req_ready  <= 1'b1;
         sram_cs_n  <= 1'b1;
         sram_cs    <= 1'b0;
         sram_we_n  <= 1'b1;
         sram_oe_n  <= 1'b1;
         sram_dq_oe <= 1'b0;
         wr_q       <= 1'b0;
         sram_addr  <= '0;
         sram_dq_o  <= '0;
      end else if (accept) begin
         req_ready  <= 1'b0;
         sram_cs_n  <= 1'b0;
         sram_cs    <= 1'b1;
         sram_oe_n  <= req_write;
         sram_we_n  <= 1'b1;
         sram_dq_oe <= 1'b0;
         wr_q       <= req_write;
         sram_addr  <= req_addr;
         sram_dq_o  <= req_wdata;
      end else if (busy) begin
         if (done) begin
            req_ready  <= 1'b1;
            sram_cs_n  <= 1'b1;
            sram_cs    <= 1'b0;
            sram_oe_n  <= 1'b1;
            sram_we_n  <= 1'b1;
            sram_dq_oe <= 1'b0;
         end else if (wr_q) begin
            if (k == CW'(WE_ON)) begin
               sram_we_n  <= 1'b0;
               sram_dq_oe <= 1'b1;
            end
            if (k == CW'(WE_OFF))  sram_we_n  <= 1'b1;
            if (k == CW'(DRV_OFF)) sram_dq_oe <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/sramc_chk.sv
module sramc_chk
   import sramc_pkg::*;
#(
   parameter int AW      = 13,
   parameter int CLK_NS  = 4,
   parameter int T_WP_NS = 55,
   parameter int T_DS_NS = 40
) (
   input logic          clk,
   input logic          rst,
   input logic          req_valid,
   input logic          req_ready,
   input logic          rd_valid,
   input logic [AW-1:0] sram_addr,
   input logic          sram_cs_n,
   input logic          sram_cs,
   input logic          sram_we_n,
   input logic          sram_oe_n,
   input logic          sram_dq_oe
);

   localparam int WP_C = max2(ceil_div(T_WP_NS, CLK_NS), ceil_div(T_DS_NS, CLK_NS));

   int wlow;
   always_ff @(posedge clk) begin
      if (rst)             wlow <= 0;
      else if (!sram_we_n) wlow <= wlow + 1;
      else                 wlow <= 0;
   end

   p_accept_r2: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready) |=> !req_ready);

   p_busy_ready_r2: assert property (@(posedge clk) disable iff (rst)
      !sram_cs_n |-> !req_ready);

   p_rv_pulse_r4: assert property (@(posedge clk) disable iff (rst)
      rd_valid |=> !rd_valid);

   p_no_fight_r5: assert property (@(posedge clk) disable iff (rst)
      sram_dq_oe |-> sram_oe_n);

   p_oe_first_r5: assert property (@(posedge clk) disable iff (rst)
      $fell(sram_we_n) |-> $past(sram_oe_n));

   p_pulse_len_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(sram_we_n) |-> (wlow == WP_C));

   p_drv_window_r7: assert property (@(posedge clk) disable iff (rst)
      sram_dq_oe |-> (!sram_we_n || $past(!sram_we_n)));

   p_we_sel_r8: assert property (@(posedge clk) disable iff (rst)
      !sram_we_n |-> (!sram_cs_n && sram_cs));

   p_addr_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr));

endmodule

bind sramc sramc_chk #(
   .AW      (AW),
   .CLK_NS  (CLK_NS),
   .T_WP_NS (T_WP_NS),
   .T_DS_NS (T_DS_NS)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .rd_valid   (rd_valid),
   .sram_addr  (sram_addr),
   .sram_cs_n  (sram_cs_n),
   .sram_cs    (sram_cs),
   .sram_we_n  (sram_we_n),
   .sram_oe_n  (sram_oe_n),
   .sram_dq_oe (sram_dq_oe)
);

// File: tb/sim_sramc.sv
`timescale 1ns/1ps
module sim_sramc;

   // expected counts at 4 ns: ceil(85/4)=22, ceil(55/4)=14 > ceil(40/4)=10
   localparam int ACC_B  = 22;
   localparam int TURN_B = 2;
   localparam int WP_B   = 14;
   localparam int RD_B   = 22;
   localparam int WR_B   = 22;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [12:0] req_addr  = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_ready, rd_valid;
   logic [7:0]  rd_data;
   logic [12:0] sram_addr;
   logic        sram_cs_n, sram_cs, sram_we_n, sram_oe_n, sram_dq_oe;
   logic [7:0]  sram_dq_o, sram_dq_i;

   always #2 clk = ~clk;

   sramc u0 (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .sram_addr(sram_addr),
      .sram_cs_n(sram_cs_n), .sram_cs(sram_cs), .sram_we_n(sram_we_n),
      .sram_oe_n(sram_oe_n), .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe),
      .sram_dq_i(sram_dq_i)
   );

   int checks = 0;
   int failures = 0;
   int cyc = 0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
      end
   endtask

   // ---------------- memory model driven by the pins ----------------
   logic [7:0] smem [256];
   int         age = 0;
   logic       we_prev = 1'b1;
   wire        rd_sel = !sram_cs_n && sram_cs && sram_we_n && !sram_oe_n;

   assign sram_dq_i = (rd_sel && age >= ACC_B - 1) ? smem[sram_addr[7:0]] : 8'hEE;

   always @(posedge clk) begin
      age     <= rd_sel ? age + 1 : 0;
      we_prev <= sram_we_n;
      if (!we_prev && sram_we_n && !sram_cs_n && sram_cs && sram_dq_oe)
         smem[sram_addr[7:0]] <= sram_dq_o;
   end

   // ---------------- behavioural reference ----------------
   logic [7:0]  ref_mem [256];
   bit          m_busy = 0, m_wr = 0;
   int          k = 0;
   logic [12:0] m_a = '0;
   logic [7:0]  m_d = '0;
   bit e_ready = 1, e_csn = 1, e_cs = 0, e_wen = 1, e_oen = 1, e_dqoe = 0, e_rv = 0;
   logic [7:0]  e_rd = '0;

   always @(posedge clk) begin
      cyc++;
      if (rst) begin
         m_busy = 0; e_ready = 1; e_csn = 1; e_cs = 0;
         e_wen = 1; e_oen = 1; e_dqoe = 0; e_rv = 0;
      end else begin
         e_rv = 0;
         if (!m_busy) begin
            if (req_valid) begin
               m_busy = 1; k = 0; m_wr = req_write; m_a = req_addr; m_d = req_wdata;
               e_ready = 0; e_csn = 0; e_cs = 1; e_oen = req_write; e_wen = 1; e_dqoe = 0;
            end
         end else begin
            k++;
            if (m_wr) begin
               if (k == TURN_B) begin e_wen = 0; e_dqoe = 1; end
               if (k == TURN_B + WP_B) e_wen = 1;
               if (k == TURN_B + WP_B + 1) e_dqoe = 0;
               if (k == WR_B) begin
                  ref_mem[m_a[7:0]] = m_d;
                  m_busy = 0; e_ready = 1; e_csn = 1; e_cs = 0; e_oen = 1; e_wen = 1; e_dqoe = 0;
               end
            end else begin
               if (k == ACC_B) begin e_rv = 1; e_rd = ref_mem[m_a[7:0]]; end
               if (k == RD_B) begin
                  m_busy = 0; e_ready = 1; e_csn = 1; e_cs = 0; e_oen = 1;
               end
            end
         end
      end
   end

   // compare on the falling edge, half a period after the producing edge
   always @(negedge clk) begin
      check(req_ready == e_ready, "R2 ready", req_ready, e_ready);
      check({sram_cs_n, sram_cs} == {e_csn, e_cs}, "R8 selects", {sram_cs_n, sram_cs}, {e_csn, e_cs});
      check(sram_oe_n == e_oen, "R3,R5 oe_n", sram_oe_n, e_oen);
      check(sram_we_n == e_wen, "R5,R6 we_n", sram_we_n, e_wen);
      check(sram_dq_oe == e_dqoe, "R7 dq_oe", sram_dq_oe, e_dqoe);
      check(rd_valid == e_rv, "R4 rd_valid", rd_valid, e_rv);
      if (e_rv)   check(rd_data == e_rd, "R4 rd_data", rd_data, e_rd);
      if (e_dqoe) check(sram_dq_o == m_d, "R7 dq_o", sram_dq_o, m_d);
      if (!e_csn) check(sram_addr == m_a, "R8 addr", sram_addr, m_a);
   end

   // ---------------- stimulus ----------------
   task automatic issue(input bit wr, input logic [12:0] a, input logic [7:0] d);
      req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 0;
   endtask

   // R2: change the request fields while busy, valid low
   task automatic noise();
      while (!req_ready) begin
         req_write = 1'($urandom);
         req_addr  = 13'($urandom);
         req_wdata = 8'($urandom);
         @(negedge clk);
      end
   endtask

   always @(posedge clk) begin
      if (cyc >= 150000) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) begin smem[i] = '0; ref_mem[i] = '0; end
      repeat (3) @(negedge clk);
      // R1: idle state under reset
      check({req_ready, sram_cs_n, sram_cs, sram_we_n, sram_oe_n, sram_dq_oe, rd_valid} == 7'b1101100,
            "R1 reset state", {req_ready, sram_cs_n, sram_cs, sram_we_n, sram_oe_n, sram_dq_oe, rd_valid}, 7'b1101100);
      rst = 0;
      @(negedge clk);
      check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
      // R5 R6 R7: writes with edge-case data patterns, back to back
      issue(1, 13'h0000, 8'h00);
      issue(1, 13'h1FFF, 8'hFF);
      issue(1, 13'h0A01, 8'hA5);
      issue(1, 13'h1502, 8'h5A);
      noise();
      // R3 R4: read them back, back to back
      issue(0, 13'h0000, 8'h00);
      issue(0, 13'h1FFF, 8'h00);
      noise();
      issue(0, 13'h0A01, 8'h00);
      issue(0, 13'h1502, 8'h00);
      // mixed traffic with idle gaps
      for (int n = 0; n < 40; n++) begin
         logic [12:0] a;
         a = 13'($urandom) & 13'h1F0F;
         issue(1'($urandom), a, 8'($urandom));
         if (n % 3 == 0) noise();
         repeat (n % 4) @(negedge clk);
      end
      while (!req_ready) @(negedge clk);
      repeat (3) @(negedge clk);
      // R7: pin-level memory matches the reference contents
      for (int i = 0; i < 256; i++)
         if (smem[i] !== ref_mem[i]) check(0, "R7 stored byte", smem[i], ref_mem[i]);
      check(1, "R7 store sweep", 0, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule